// File: doc/BRIEF.md
# MESI Snooping Line-State Controller

This block tracks the coherence state of every line in a small direct-mapped tag array that sits on a shared snooping bus. Each line keeps an address tag and one of four states. The processor presents a read or write request with a line address and holds it until `cpu_done` goes high. The controller answers at once when no bus traffic is needed. Otherwise it raises a bus request, holds it until the bus grants it, and then finishes the access in the grant cycle. Data movement is not modelled. Only the bus commands and the writeback strobes are produced.

Other agents' bus transactions arrive on the snoop inputs. The controller reports a shared copy on snooped reads, and raises a writeback strobe when a snoop hits a dirty line. It then downgrades or invalidates the line in the same clock. Because a clean private line is held in the Exclusive state, it can be written without any bus transaction.

Top module: `mesi_line_ctl`

## Requirements
- R1: After reset every line is Invalid, so the first access to any address misses and requests the bus.
- R2: A read that misses issues bus command 0 (read). At the grant, the line takes the requested tag. It becomes Shared (state code 1) if `bus_shared` is high in the grant cycle, and Exclusive (code 2) otherwise. `cpu_done` rises in the grant cycle.
- R3: A write that hits an Exclusive line completes in the same cycle with no bus request, and the line becomes Modified (code 3).
- R4: A write that hits a Shared line issues command 2 (upgrade). A write to an Invalid line or to a miss issues command 1 (read-for-ownership). In both cases the line is Modified after the grant, and `cpu_done` rises in the grant cycle.
- R5: A read hit in Modified, Exclusive or Shared state, and a write hit in Modified state, complete in the request cycle with no bus request. The state does not change.
- R6: A snooped read (snoop code 0) that matches a valid line raises `snp_shared` in that cycle. A Modified line also raises `snp_wb`. Modified and Exclusive lines move to Shared.
- R7: A snooped read-for-ownership (code 1) or upgrade (code 2) that matches a valid line invalidates it. `snp_wb` is raised only if the line was Modified, and `snp_shared` stays low.
- R8: A miss whose victim line is Modified first issues command 3 (writeback) with the victim's address `{old tag, index}`. That grant makes the victim Invalid without completing the request, and the fill request follows.
- R9: When a snoop and a processor request address the same index in one cycle, the snoop is applied. The processor request makes no bus request and does not complete in that cycle.
- R10: While a bus request waits for `bus_gnt`, the request, command and address stay asserted and `cpu_done` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Processor request valid, held until done |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Line address {tag, index} |
| cpu_done | output | 1 | Request completes this cycle |
| bus_req | output | 1 | Bus transaction request |
| bus_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 upgrade, 3 writeback |
| bus_addr | output | AW | Line address of the bus transaction |
| bus_gnt | input | 1 | Bus grant; the transaction completes in this cycle |
| bus_shared | input | 1 | Another cache holds the line (sampled at grant) |
| snp_valid | input | 1 | Snooped transaction present |
| snp_cmd | input | 2 | 0 read, 1 read-for-ownership, 2 upgrade |
| snp_addr | input | AW | Snooped line address |
| snp_shared | output | 1 | This cache holds a valid copy of the snooped read line |
| snp_wb | output | 1 | Dirty line written back in answer to the snoop |

## Verification
A wrong line state shows at the ports on the next access to that index. A lost Modified state removes the `snp_wb` pulse on a later snoop. A wrong Exclusive/Shared choice turns a silent write into an upgrade request, or the reverse. A stale tag turns a hit into a bus request. All outputs are combinational from the stored state and the current inputs, so each of these mismatches appears in the first cycle that touches the line. Random traffic on a few tags per index keeps victims, snoops and collisions frequent enough to expose such errors quickly.

// File: rtl/mesi_pkg.sv
`timescale 1ns/1ps
package mesi_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} line_st_e;
  typedef enum logic [1:0] {BC_RD = 2'd0, BC_RDX = 2'd1, BC_UPG = 2'd2, BC_WB = 2'd3} bus_cmd_e;

  function automatic logic is_hit(input line_st_e st, input logic [31:0] stored, input logic [31:0] wanted);
    return (st != ST_I) && (stored == wanted);
  endfunction

  // state a line takes when a fill completes
  function automatic line_st_e fill_state(input logic for_write, input logic others_have);
    if (for_write) return ST_M;
    return others_have ? ST_S : ST_E;
  endfunction

  // state after a matching snoop
  function automatic line_st_e snoop_next(input line_st_e st, input logic is_read);
    if (!is_read) return ST_I;
    return (st == ST_I) ? ST_I : ST_S;
  endfunction
endpackage

// File: rtl/mesi_tag_array.sv
`timescale 1ns/1ps
module mesi_tag_array
  import mesi_pkg::*;
#(
  parameter int NLINES = 8,
  parameter int IDXW   = 3,
  parameter int TAGW   = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IDXW-1:0] pa_idx,
  output logic [TAGW-1:0] pa_tag,
  output line_st_e        pa_st,
  input  logic [IDXW-1:0] pb_idx,
  output logic [TAGW-1:0] pb_tag,
  output line_st_e        pb_st,
  input  logic            la_en,
  input  logic [IDXW-1:0] la_idx,
  input  line_st_e        la_st,
  input  logic            la_tag_en,
  input  logic [TAGW-1:0] la_tag,
  input  logic            sb_en,
  input  logic [IDXW-1:0] sb_idx,
  input  line_st_e        sb_st,
  output line_st_e        st_all [NLINES]
);
  line_st_e        st_q  [NLINES];
  logic [TAGW-1:0] tag_q [NLINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NLINES; i++) begin
        st_q[i]  <= ST_I;
        tag_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NLINES; i++) begin
        if (sb_en && sb_idx == IDXW'(i))      st_q[i] <= sb_st;
        else if (la_en && la_idx == IDXW'(i)) st_q[i] <= la_st;
        if (la_en && la_tag_en && la_idx == IDXW'(i)) tag_q[i] <= la_tag;
      end
    end
  end

  assign pa_tag = tag_q[pa_idx];
  assign pa_st  = st_q[pa_idx];
  assign pb_tag = tag_q[pb_idx];
  assign pb_st  = st_q[pb_idx];
  assign st_all = st_q;

  AST_WRITERS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    (la_en && sb_en) |-> (la_idx != sb_idx)); // R9
endmodule

// File: rtl/mesi_local_ctl.sv
`timescale 1ns/1ps
module mesi_local_ctl
  import mesi_pkg::*;
#(
  parameter int AW   = 12,
  parameter int IDXW = 3
) (
  input  logic                 req,
  input  logic                 we,
  input  logic [AW-1:0]        addr,
  input  logic [AW-IDXW-1:0]   line_tag,
  input  line_st_e             line_st,
  input  logic                 blocked,
  input  logic                 gnt,
  input  logic                 shared_in,
  output logic                 done,
  output logic                 bus_req,
  output bus_cmd_e             bus_cmd,
  output logic [AW-1:0]        bus_addr,
  output logic                 upd_en,
  output line_st_e             upd_st,
  output logic                 upd_tag
);
  localparam int TAGW = AW - IDXW;
  logic [TAGW-1:0] req_tag;
  logic            hit;
  logic            active;

  assign req_tag = addr[AW-1:IDXW];

  always_comb begin
    done     = 1'b0;
    bus_req  = 1'b0;
    bus_cmd  = BC_RD;
    bus_addr = addr;
    upd_en   = 1'b0;
    upd_st   = line_st;
    upd_tag  = 1'b0;
    active   = req && !blocked;
    hit      = is_hit(line_st, 32'(line_tag), 32'(req_tag));
    if (active) begin
      if (hit && (!we || line_st == ST_M)) begin
        done = 1'b1;
      end else if (hit && line_st == ST_E) begin
        done   = 1'b1;
        upd_en = 1'b1;
        upd_st = ST_M;
      end else if (hit) begin
        bus_req = 1'b1;
        bus_cmd = BC_UPG;
        if (gnt) begin
          done   = 1'b1;
          upd_en = 1'b1;
          upd_st = ST_M;
        end
      end else if (line_st == ST_M) begin
        bus_req  = 1'b1;
        bus_cmd  = BC_WB;
        bus_addr = {line_tag, addr[IDXW-1:0]};
        if (gnt) begin
          upd_en = 1'b1;
          upd_st = ST_I;
        end
      end else begin
        bus_req = 1'b1;
        bus_cmd = we ? BC_RDX : BC_RD;
        if (gnt) begin
          done    = 1'b1;
          upd_en  = 1'b1;
          upd_tag = 1'b1;
          upd_st  = fill_state(we, shared_in);
        end
      end
    end
  end
endmodule

// File: rtl/mesi_snoop_ctl.sv
`timescale 1ns/1ps
module mesi_snoop_ctl
  import mesi_pkg::*;
#(
  parameter int TAGW = 9
) (
  input  logic            valid,
  input  logic [1:0]      cmd,
  input  logic [TAGW-1:0] snp_tag,
  input  logic [TAGW-1:0] line_tag,
  input  line_st_e        line_st,
  output logic            shared_o,
  output logic            wb_o,
  output logic            upd_en,
  output line_st_e        upd_st
);
  logic match;
  logic is_read;

  assign is_read  = (cmd == 2'(BC_RD));
  assign match    = valid && is_hit(line_st, 32'(line_tag), 32'(snp_tag));
  assign shared_o = match && is_read;
  assign wb_o     = match && (line_st == ST_M);
  assign upd_en   = match;
  assign upd_st   = snoop_next(line_st, is_read);
endmodule

// File: rtl/mesi_line_ctl.sv
`timescale 1ns/1ps
module mesi_line_ctl
  import mesi_pkg::*;
#(
  parameter int AW     = 12,
  parameter int NLINES = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  output logic          cpu_done,
  output logic          bus_req,
  output logic [1:0]    bus_cmd,
  output logic [AW-1:0] bus_addr,
  input  logic          bus_gnt,
  input  logic          bus_shared,
  input  logic          snp_valid,
  input  logic [1:0]    snp_cmd,
  input  logic [AW-1:0] snp_addr,
  output logic          snp_shared,
  output logic          snp_wb
);
  localparam int IDXW = $clog2(NLINES);
  localparam int TAGW = AW - IDXW;

  logic [IDXW-1:0] cpu_idx, snp_idx;
  logic [TAGW-1:0] cpu_line_tag, snp_line_tag;
  line_st_e        cpu_line_st, snp_line_st;
  logic            collide;
  logic            lc_upd_en, lc_upd_tag, sc_upd_en;
  line_st_e        lc_upd_st, sc_upd_st;
  bus_cmd_e        lc_cmd;
  line_st_e        st_all [NLINES];

  assign cpu_idx = cpu_addr[IDXW-1:0];
  assign snp_idx = snp_addr[IDXW-1:0];
  assign collide = snp_valid && cpu_req && (snp_idx == cpu_idx);

  mesi_tag_array #(.NLINES(NLINES), .IDXW(IDXW), .TAGW(TAGW)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .pa_idx(cpu_idx), .pa_tag(cpu_line_tag), .pa_st(cpu_line_st),
    .pb_idx(snp_idx), .pb_tag(snp_line_tag), .pb_st(snp_line_st),
    .la_en(lc_upd_en), .la_idx(cpu_idx), .la_st(lc_upd_st),
    .la_tag_en(lc_upd_tag), .la_tag(cpu_addr[AW-1:IDXW]),
    .sb_en(sc_upd_en), .sb_idx(snp_idx), .sb_st(sc_upd_st),
    .st_all(st_all)
  );

  mesi_local_ctl #(.AW(AW), .IDXW(IDXW)) u_local (
    .req(cpu_req), .we(cpu_we), .addr(cpu_addr),
    .line_tag(cpu_line_tag), .line_st(cpu_line_st), .blocked(collide),
    .gnt(bus_gnt), .shared_in(bus_shared),
    .done(cpu_done), .bus_req(bus_req), .bus_cmd(lc_cmd), .bus_addr(bus_addr),
    .upd_en(lc_upd_en), .upd_st(lc_upd_st), .upd_tag(lc_upd_tag)
  );

  assign bus_cmd = lc_cmd;

  mesi_snoop_ctl #(.TAGW(TAGW)) u_snoop (
    .valid(snp_valid), .cmd(snp_cmd), .snp_tag(snp_addr[AW-1:IDXW]),
    .line_tag(snp_line_tag), .line_st(snp_line_st),
    .shared_o(snp_shared), .wb_o(snp_wb),
    .upd_en(sc_upd_en), .upd_st(sc_upd_st)
  );

  // event taps for the assertions
  logic [IDXW-1:0] prev_cpu_idx, prev_snp_idx;
  line_st_e        st_prev_cpu, st_prev_snp;
  logic            fill_rd_evt, wait_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_cpu_idx <= '0;
      prev_snp_idx <= '0;
    end else begin
      prev_cpu_idx <= cpu_idx;
      prev_snp_idx <= snp_idx;
    end
  end

  assign st_prev_cpu = st_all[prev_cpu_idx];
  assign st_prev_snp = st_all[prev_snp_idx];
  assign fill_rd_evt = bus_req && bus_gnt && (bus_cmd == 2'(BC_RD));
  assign wait_evt    = bus_req && !bus_gnt;

  AST_FILL_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    fill_rd_evt |=> (st_prev_cpu == ($past(bus_shared) ? ST_S : ST_E))); // R2
  AST_WRITE_ENDS_M: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_done && cpu_we) |=> (st_prev_cpu == ST_M)); // R3
  AST_VICTIM_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && (bus_cmd == 2'(BC_RD) || bus_cmd == 2'(BC_RDX))) |-> (cpu_line_st != ST_M)); // R8
  AST_SNOOP_DROPS_M: assert property (@(posedge clk) disable iff (!rst_n)
    snp_wb |=> (st_prev_snp != ST_M)); // R6
  AST_SNOOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    collide |-> (!cpu_done && !bus_req)); // R9
  AST_WAIT_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    wait_evt |-> !cpu_done); // R10
endmodule

// File: tb/sim_mesi_line_ctl.sv
`timescale 1ns/1ps
module sim_mesi_line_ctl;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          cpu_req = 0, cpu_we = 0, bus_gnt = 0, bus_shared = 0, snp_valid = 0;
  logic [AW-1:0] cpu_addr = '0, snp_addr = '0;
  logic [1:0]    snp_cmd = '0;
  logic          cpu_done, bus_req, snp_shared, snp_wb;
  logic [1:0]    bus_cmd;
  logic [AW-1:0] bus_addr;

  mesi_line_ctl #(.AW(AW), .NLINES(8)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_done(cpu_done),
    .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_gnt(bus_gnt), .bus_shared(bus_shared),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_shared(snp_shared), .snp_wb(snp_wb)
  );

  // stimulus registers
  logic          r_req = 0, r_we = 0, r_sv = 0, r_gnt = 0, r_shr = 0;
  logic [AW-1:0] r_addr = '0, r_saddr = '0;
  logic [1:0]    r_scmd = '0;
  logic          last_done = 0;

  // model: 0 Invalid, 1 Shared, 2 Exclusive, 3 Modified
  logic [8:0] m_tag [8];
  logic [1:0] m_st  [8];
  int nvec = 0, nbad = 0;

  function automatic logic [AW-1:0] mk(input int t, input int i);
    return {9'(t), 3'(i)};
  endfunction

  task automatic chk(input string tg, input string what, input int got, input int exp, inout logic bad);
    if (got != exp) begin
      $display("FAIL %s %s got %0d exp %0d", tg, what, got, exp);
      bad = 1'b1;
    end
  endtask

  task automatic step(input string tg);
    logic e_done, e_breq, e_sh, e_wb, bad, lhit, shit, coll, fire;
    logic [1:0] e_cmd, nst;
    logic [AW-1:0] e_addr;
    int li, si;
    @(negedge clk);
    cpu_req = r_req; cpu_we = r_we; cpu_addr = r_addr;
    snp_valid = r_sv; snp_cmd = r_scmd; snp_addr = r_saddr;
    bus_gnt = r_gnt; bus_shared = r_shr;
    #1;
    li = int'(r_addr[2:0]); si = int'(r_saddr[2:0]);
    coll = r_sv && r_req && (li == si);
    shit = r_sv && m_st[si] != 2'd0 && m_tag[si] == r_saddr[11:3];
    e_sh = shit && r_scmd == 2'd0;
    e_wb = shit && m_st[si] == 2'd3;
    e_done = 0; e_breq = 0; e_cmd = 0; e_addr = r_addr; fire = 0; nst = m_st[li];
    lhit = m_st[li] != 2'd0 && m_tag[li] == r_addr[11:3];
    if (r_req && !coll) begin
      if (lhit && (!r_we || m_st[li] == 2'd3)) e_done = 1;
      else if (lhit && m_st[li] == 2'd2) begin e_done = 1; nst = 2'd3; end
      else if (lhit) begin e_breq = 1; e_cmd = 2'd2; if (r_gnt) begin e_done = 1; nst = 2'd3; end end
      else if (m_st[li] == 2'd3) begin
        e_breq = 1; e_cmd = 2'd3; e_addr = {m_tag[li], r_addr[2:0]};
        if (r_gnt) nst = 2'd0;
      end else begin
        e_breq = 1; e_cmd = r_we ? 2'd1 : 2'd0;
        if (r_gnt) begin e_done = 1; fire = 1; nst = r_we ? 2'd3 : (r_shr ? 2'd1 : 2'd2); end
      end
    end
    nvec++; bad = 0;
    chk(tg, "cpu_done", int'(cpu_done), int'(e_done), bad);
    chk(tg, "bus_req", int'(bus_req), int'(e_breq), bad);
    if (e_breq) begin
      chk(tg, "bus_cmd", int'(bus_cmd), int'(e_cmd), bad);
      chk(tg, "bus_addr", int'(bus_addr), int'(e_addr), bad);
    end
    chk(tg, "snp_shared", int'(snp_shared), int'(e_sh), bad);
    chk(tg, "snp_wb", int'(snp_wb), int'(e_wb), bad);
    if (bad) nbad++;
    if (r_req && !coll) begin
      m_st[li] = nst;
      if (fire) m_tag[li] = r_addr[11:3];
    end
    if (shit) m_st[si] = (r_scmd == 2'd0) ? 2'd1 : 2'd0;
    last_done = e_done;
  endtask

  task automatic idle_all();
    r_req = 0; r_sv = 0; r_gnt = 0; r_shr = 0;
  endtask

  initial begin
    #500000;
    $display("FAIL watchdog expired");
    nbad++;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 8; i++) begin m_st[i] = 2'd0; m_tag[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step("R1 idle");
    // R1 / R10: first read misses and waits for the grant
    r_req = 1; r_we = 0; r_addr = mk(2, 0); r_gnt = 0;
    step("R1 R10 wait"); step("R10 wait");
    r_gnt = 1; r_shr = 0; step("R2 fill exclusive");
    r_gnt = 0; r_we = 1; step("R3 silent write");
    idle_all(); r_sv = 1; r_scmd = 2'd0; r_saddr = mk(2, 0); step("R6 snoop read on M");
    idle_all(); r_req = 1; r_we = 0; r_addr = mk(2, 0); step("R5 read hit shared");
    r_we = 1; r_gnt = 0; step("R4 R10 upgrade wait");
    r_gnt = 1; step("R4 upgrade grant");
    idle_all(); r_sv = 1; r_scmd = 2'd1; r_saddr = mk(2, 0); step("R7 rdx on M");
    idle_all(); r_req = 1; r_we = 0; r_addr = mk(2, 1); r_gnt = 1; r_shr = 1; step("R2 fill shared");
    idle_all(); r_sv = 1; r_scmd = 2'd2; r_saddr = mk(2, 1); step("R7 upgrade on S");
    idle_all(); r_req = 1; r_we = 0; r_addr = mk(2, 1); r_gnt = 0; step("R7 line gone");
    idle_all(); r_req = 1; r_we = 1; r_addr = mk(3, 2); r_gnt = 1; step("R4 rdx fill");
    idle_all(); r_req = 1; r_we = 0; r_addr = mk(5, 2); r_gnt = 0; step("R8 victim wb wait");
    r_gnt = 1; step("R8 victim wb grant");
    r_shr = 0; step("R8 refill");
    idle_all(); r_req = 1; r_we = 0; r_addr = mk(5, 2);
    r_sv = 1; r_scmd = 2'd0; r_saddr = mk(5, 2); step("R9 snoop wins");
    r_sv = 0; step("R5 after collision");
    idle_all(); r_req = 1; r_we = 1; r_addr = mk(5, 2); r_gnt = 0; step("R4 upgrade after snoop");
    idle_all();
    for (int k = 0; k < 4000; k++) begin
      if (!r_req || last_done) begin
        r_req = ($urandom % 10) < 6;
        r_we = 1'($urandom % 2);
        r_addr = mk(int'($urandom % 4), int'($urandom % 8));
      end
      r_sv = ($urandom % 10) < 3;
      r_scmd = 2'($urandom % 3);
      r_saddr = mk(int'($urandom % 4), int'($urandom % 8));
      r_gnt = 1'($urandom % 2);
      r_shr = 1'($urandom % 2);
      step("random R2 R3 R4 R5 R6 R7 R8 R9 R10");
    end
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule